// File: doc/BRIEF.md
# Posted-Write Register Synchronizer

This block is the bus-side front end of a peripheral whose working registers run on a separate, slower functional clock. Ten functional registers each have their own transfer channel. A bus write to one of them is held in a bus-side buffer. A toggle handshake then carries the write to the functional clock. There the value is latched, a one-cycle write strobe is raised, and an acknowledge toggle is sent back. While a transfer is in flight, that register's pending bit stays set. The pending vector can be read at any time from a status word.

Bit 2 of an interface-control word selects one of two acknowledge policies:

- **Posted mode:** the bus write completes in the cycle it is presented. The master then polls the pending bits it cares about.
- **Non-posted mode:** ready is held low until the functional domain has taken the value and the acknowledge has returned.

In both modes, a second write to a register whose previous transfer has not finished is stalled until that transfer is done.

A wakeup-enable word and a capture word are written directly in the bus domain and have no pending bit. Reads complete in one cycle. A read of a functional register returns the value most recently latched by the functional domain, brought back under the same acknowledge.

Top module: `posted_wr_sync`

## Requirements
- R1: After reset, every pending bit is 0, posted mode is off, all functional registers and direct words read 0, and the functional outputs are 0.
- R2: The interface-control word at offset 0x54 stores only bit 2 (1 = posted mode). All other bits are ignored on write and read back as 0.
- R3: In posted mode, a write to functional register i (offset 4*i, i = 0..9) whose pending bit is clear is acknowledged in the cycle it is presented, and pending bit i reads 1 right afterwards.
- R4: The write-pending status word at offset 0x48 holds pending bit i in bit position i (0 control, 1 counter, 2 load, 3 trigger, 4 match, 5 positive increment, 6 negative increment, 7 tick count, 8 overflow mask set, 9 overflow wrap count), with bits 31:10 reading 0. A write to it is acknowledged and changes nothing.
- R5: Each accepted write to register i updates functional output slice i to the written value and raises write strobe i for exactly one functional clock cycle. Pending bit i then returns to 0 without any further bus action.
- R6: In non-posted mode, a write to a functional register keeps ready low until the transfer has finished (at least 10 bus cycles with the functional clock at about an eighth of the bus clock). Its pending bit already reads 0 in the cycle after the acknowledge.
- R7: A write to a register whose pending bit is set is stalled (ready low) until the earlier transfer completes. It then proceeds, so the later value is the one that lands.
- R8: A read of functional register i returns the value last latched by the functional domain. While a new write to i is still pending, the read returns the previous value.
- R9: The wakeup-enable word (0x40) and capture word (0x44) are written in one cycle with no pending bit, read back as written, and drive their output ports.
- R10: Reads of unmapped or unaligned offsets return 0. Writes to them are acknowledged in one cycle and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| fclk | input | 1 | Functional clock |
| frst | input | 1 | Synchronous active-high reset, functional domain |
| bus_req | input | 1 | Request valid, held until bus_ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | DW | Write data |
| bus_ready | output | 1 | Request completes on this cycle |
| bus_rdata | output | DW | Read data, valid with bus_ready on a read |
| f_regs | output | 10*DW | Functional-domain register values, slice i = register i |
| f_wstb | output | 10 | One-cycle write strobe per register, functional domain |
| wake_en | output | DW | Wakeup-enable word |
| capt_val | output | DW | Capture word |

## Verification
The assertions assume that a master keeps bus_req, bus_we, bus_addr and bus_wdata steady from the cycle a request is raised until bus_ready is seen. They also assume that the two resets are asserted together, so the request and acknowledge toggles start equal. The stimulus drives one request at a time, changes the inputs only between edges, and drops bus_req just after the accepting edge. It applies both resets over several functional clock cycles and releases them together. The timing-dependent checks (pending still set after a burst, stall lengths) rely on the functional clock being much slower than the bus clock, which the stimulus fixes.

// File: rtl/pws_pkg.sv
`timescale 1ns/1ps
package pws_pkg;

    // Number of functional registers that carry a pending bit; the bit order
    // is decoded by software and must stay fixed.
    localparam int NUM_CHAN = 10;
    localparam int ADDR_W   = 8;
    localparam int IDX_W    = $clog2(NUM_CHAN);
    localparam int PAD_N    = 1 << IDX_W;

    localparam logic [ADDR_W-1:0] OFF_WAKE = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_CAPT = 8'h44;
    localparam logic [ADDR_W-1:0] OFF_PEND = 8'h48;
    localparam logic [ADDR_W-1:0] OFF_IFC  = 8'h54;
    localparam int POSTED_BIT = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } bus_st_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } chan_sel_t;

    // Functional register i lives at byte offset 4*i.
    function automatic chan_sel_t decode_chan(input logic [ADDR_W-1:0] a);
        chan_sel_t s;
        s.idx = a[IDX_W+1:2];
        s.hit = (a[1:0] == 2'b00) && (int'(a[ADDR_W-1:2]) < NUM_CHAN);
        return s;
    endfunction

endpackage

// File: rtl/pws_sync.sv
`timescale 1ns/1ps
module pws_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pws_chan.sv
`timescale 1ns/1ps
module pws_chan #(
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fclk,
    input  logic          frst,
    input  logic          launch,
    input  logic [DW-1:0] wdata,
    output logic          pending,
    output logic [DW-1:0] rd_val,
    output logic [DW-1:0] f_val,
    output logic          f_stb
);
    // bus-domain side
    logic          req_tog;
    logic [DW-1:0] hold;
    logic          ack_tog;
    logic          ack_s;
    logic          ack_s_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_tog <= 1'b0;
            hold    <= '0;
        end else if (launch) begin
            hold    <= wdata;
            req_tog <= ~req_tog;
        end
    end

    pws_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (ack_tog),
        .q   (ack_s)
    );

    // f_val has been stable since ack_tog moved, so it is safe to sample it
    // on the acknowledge edge; pending drops on that same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            ack_s_d <= 1'b0;
            rd_val  <= '0;
        end else begin
            ack_s_d <= ack_s;
            if (ack_s != ack_s_d) rd_val <= f_val;
        end
    end

    assign pending = req_tog ^ ack_s_d;

    // functional-domain side
    logic req_s;
    logic req_s_d;

    pws_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (fclk),
        .rst (frst),
        .d   (req_tog),
        .q   (req_s)
    );

    always_ff @(posedge fclk) begin
        if (frst) begin
            req_s_d <= 1'b0;
            ack_tog <= 1'b0;
            f_val   <= '0;
            f_stb   <= 1'b0;
        end else begin
            req_s_d <= req_s;
            f_stb   <= 1'b0;
            if (req_s != req_s_d) begin
                f_val   <= hold;
                f_stb   <= 1'b1;
                ack_tog <= req_s;
            end
        end
    end
endmodule

// File: rtl/pws_bus.sv
`timescale 1ns/1ps
module pws_bus
    import pws_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    input  logic [NUM_CHAN-1:0]  pending,
    input  logic [NUM_CHAN*DW-1:0] rd_vals,
    output logic                 bus_ready,
    output logic [DW-1:0]        bus_rdata,
    output logic [NUM_CHAN-1:0]  launch,
    output logic                 posted_q,
    output logic [DW-1:0]        wake_q,
    output logic [DW-1:0]        capt_q
);
    chan_sel_t          sel;
    bus_st_e            st, st_nxt;
    logic [IDX_W-1:0]   wait_idx;
    logic [PAD_N-1:0]   pend_pad;
    logic [PAD_N-1:0]   launch_pad;
    logic [DW-1:0]      rd_arr [PAD_N];

    assign sel = decode_chan(bus_addr);

    always_comb begin
        pend_pad = '0;
        pend_pad[NUM_CHAN-1:0] = pending;
    end

    for (genvar g = 0; g < PAD_N; g++) begin : g_rd
        if (g < NUM_CHAN) begin : g_real
            assign rd_arr[g] = rd_vals[g*DW +: DW];
        end else begin : g_pad
            assign rd_arr[g] = '0;
        end
    end

    always_comb begin
        st_nxt     = st;
        bus_ready  = 1'b0;
        launch_pad = '0;
        unique case (st)
            ST_IDLE: begin
                if (bus_req) begin
                    if (bus_we && sel.hit) begin
                        if (!pend_pad[sel.idx]) begin
                            launch_pad[sel.idx] = 1'b1;
                            if (posted_q) bus_ready = 1'b1;
                            else          st_nxt    = ST_WAIT;
                        end
                    end else begin
                        bus_ready = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (bus_req && !pend_pad[wait_idx]) begin
                    bus_ready = 1'b1;
                    st_nxt    = ST_IDLE;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    assign launch = launch_pad[NUM_CHAN-1:0];

    logic dir_wr;
    assign dir_wr = bus_req && bus_we && bus_ready && !sel.hit && (st == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            wait_idx <= '0;
            posted_q <= 1'b0;
            wake_q   <= '0;
            capt_q   <= '0;
        end else begin
            st <= st_nxt;
            if (|launch_pad) wait_idx <= sel.idx;
            if (dir_wr) begin
                case (bus_addr)
                    OFF_WAKE: wake_q   <= bus_wdata;
                    OFF_CAPT: capt_q   <= bus_wdata;
                    OFF_IFC:  posted_q <= bus_wdata[POSTED_BIT];
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel.hit) begin
            bus_rdata = rd_arr[sel.idx];
        end else begin
            case (bus_addr)
                OFF_WAKE: bus_rdata = wake_q;
                OFF_CAPT: bus_rdata = capt_q;
                OFF_PEND: bus_rdata[NUM_CHAN-1:0] = pending;
                OFF_IFC:  bus_rdata[POSTED_BIT] = posted_q;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/posted_wr_sync.sv
`timescale 1ns/1ps
module posted_wr_sync
    import pws_pkg::*;
#(
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fclk,
    input  logic                    frst,
    input  logic                    bus_req,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DW-1:0]           bus_wdata,
    output logic                    bus_ready,
    output logic [DW-1:0]           bus_rdata,
    output logic [NUM_CHAN*DW-1:0]  f_regs,
    output logic [NUM_CHAN-1:0]     f_wstb,
    output logic [DW-1:0]           wake_en,
    output logic [DW-1:0]           capt_val
);
    logic [NUM_CHAN-1:0]    pend_vec;
    logic [NUM_CHAN-1:0]    launch;
    logic [NUM_CHAN*DW-1:0] rd_vals;
    logic                   posted_mode;

    pws_bus #(.DW(DW)) u_bus (
        .clk       (clk),
        .rst       (rst),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pending   (pend_vec),
        .rd_vals   (rd_vals),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata),
        .launch    (launch),
        .posted_q  (posted_mode),
        .wake_q    (wake_en),
        .capt_q    (capt_val)
    );

    for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
        pws_chan #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .fclk    (fclk),
            .frst    (frst),
            .launch  (launch[g]),
            .wdata   (bus_wdata),
            .pending (pend_vec[g]),
            .rd_val  (rd_vals[g*DW +: DW]),
            .f_val   (f_regs[g*DW +: DW]),
            .f_stb   (f_wstb[g])
        );
    end
endmodule

// File: rtl/posted_wr_sync_chk.sv
`timescale 1ns/1ps
module posted_wr_sync_chk
    import pws_pkg::*;
#(
    parameter int DW = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_req,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_ready,
    input logic [DW-1:0]       bus_rdata,
    input logic [NUM_CHAN-1:0] pend_vec,
    input logic                posted_mode
);
    chan_sel_t        s;
    logic [PAD_N-1:0] pp;
    logic [DW-1:0]    pend_word;

    assign s = decode_chan(bus_addr);

    always_comb begin
        pp = '0;
        pp[NUM_CHAN-1:0] = pend_vec;
        pend_word = '0;
        pend_word[NUM_CHAN-1:0] = pend_vec;
    end

    AST_POSTED_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_ready && s.hit && posted_mode) |=> pp[$past(s.idx)]); // R3

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && s.hit && pp[s.idx]) |-> !bus_ready); // R7

    AST_NP_ACK_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && s.hit && bus_ready && !posted_mode) |-> !pp[s.idx]); // R6

    AST_ONE_RISE: assert property (@(posedge clk) disable iff (rst)
        $countones(pend_vec & ~$past(pend_vec)) <= 1); // R5

    AST_PEND_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_addr == OFF_PEND) |-> (bus_ready && bus_rdata == pend_word)); // R4
endmodule

bind posted_wr_sync posted_wr_sync_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_ready   (bus_ready),
    .bus_rdata   (bus_rdata),
    .pend_vec    (pend_vec),
    .posted_mode (posted_mode)
);

// File: tb/sim_posted_wr_sync.sv
`timescale 1ns/1ps
module sim_posted_wr_sync;
    localparam int DW = 32;
    localparam int NC = 10;

    logic clk = 1'b0;
    logic fclk = 1'b0;
    logic rst = 1'b1;
    logic frst = 1'b1;
    logic bus_req = 1'b0;
    logic bus_we = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic bus_ready;
    logic [DW-1:0] bus_rdata;
    logic [NC*DW-1:0] f_regs;
    logic [NC-1:0] f_wstb;
    logic [DW-1:0] wake_en;
    logic [DW-1:0] capt_val;

    always #2.5 clk = ~clk;
    always #21 fclk = ~fclk;

    posted_wr_sync u0 (
        .clk(clk), .rst(rst), .fclk(fclk), .frst(frst),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .f_regs(f_regs), .f_wstb(f_wstb), .wake_en(wake_en), .capt_val(capt_val)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int stb_cnt [NC];
    int exp_cnt [NC];
    logic [DW-1:0] last [NC];

    initial for (int i = 0; i < NC; i++) begin stb_cnt[i] = 0; exp_cnt[i] = 0; last[i] = '0; end

    always @(negedge fclk) begin
        if (!frst) for (int i = 0; i < NC; i++) if (f_wstb[i]) stb_cnt[i]++;
    end

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [DW-1:0] d, output int cyc);
        logic r;
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        cyc = 0;
        while (1) begin
            #1;
            cyc++;
            r = bus_ready;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
            if (cyc > 2000) break;
        end
        #1 bus_req = 1'b0;
        if (a[1:0] == 2'b00 && a[7:2] < NC) exp_cnt[a[7:2]]++;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [DW-1:0] d);
        logic r;
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        r = bus_ready;
        d = bus_rdata;
        @(posedge clk);
        #1 bus_req = 1'b0;
        if (!r) d = 'x;
    endtask

    task automatic wait_clear();
        logic [DW-1:0] p;
        for (int k = 0; k < 300; k++) begin
            bus_rd(8'h48, p);
            if (p == '0) break;
        end
        check("R5 pending drains", p, '0);
    endtask

    initial begin
        logic [DW-1:0] d;
        logic [DW-1:0] v;
        int cyc;

        repeat (4) @(posedge fclk);
        @(negedge fclk) frst = 1'b0;
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        bus_rd(8'h48, d); check("R1 pending", d, '0);
        bus_rd(8'h54, d); check("R1 ifc", d, '0);
        bus_rd(8'h00, d); check("R1 reg0", d, '0);
        bus_rd(8'h40, d); check("R1 wake", d, '0);
        check("R1 f_regs low", f_regs[DW-1:0], '0);

        // R6 non-posted sweep over every register
        for (int i = 0; i < NC; i++) begin
            v = 32'hA5000000 + i * 32'h00010203;
            bus_wr(8'(4*i), v, cyc);
            check("R6 stall", (cyc >= 10) ? 1 : 0, 1);
            bus_rd(8'h48, d); check("R6 no pending after ack", d, '0);
            bus_rd(8'(4*i), d); check("R8 readback", d, v);
            check("R5 f_regs slice", f_regs[i*DW +: DW], v);
            last[i] = v;
        end

        // R2 interface control
        bus_wr(8'h54, 32'hFFFFFFFF, cyc);
        bus_rd(8'h54, d); check("R2 only bit2", d, 32'h4);
        bus_wr(8'h54, 32'h0, cyc);
        bus_rd(8'h54, d); check("R2 clear", d, 32'h0);
        bus_wr(8'h54, 32'h4, cyc);
        bus_rd(8'h54, d); check("R2 set", d, 32'h4);

        // R3 / R8 posted sweep
        for (int i = 0; i < NC; i++) begin
            v = 32'h3C000000 ^ (i * 32'h11111111);
            bus_wr(8'(4*i), v, cyc);
            check("R3 one cycle ack", cyc, 1);
            bus_rd(8'h48, d); check("R3 pending bit", d, 32'(1) << i);
            bus_rd(8'(4*i), d); check("R8 old value while pending", d, last[i]);
            wait_clear();
            bus_rd(8'(4*i), d); check("R8 new value", d, v);
            check("R5 f_regs slice", f_regs[i*DW +: DW], v);
            last[i] = v;
        end

        // R4 burst, bit positions, write to status ignored
        for (int i = 0; i < NC; i++) begin
            bus_wr(8'(4*i), 32'h00C00000 + i, cyc);
            check("R3 burst ack", cyc, 1);
            last[i] = 32'h00C00000 + i;
        end
        bus_rd(8'h48, d); check("R4 all pending", d, 32'h3FF);
        bus_wr(8'h48, 32'h0, cyc);
        check("R4 status write ack", cyc, 1);
        bus_rd(8'h48, d); check("R4 status write ignored", d, 32'h3FF);
        wait_clear();
        for (int i = 0; i < NC; i++) begin
            bus_rd(8'(4*i), d); check("R5 burst value", d, last[i]);
        end

        // R7 second write held off
        bus_wr(8'h0C, 32'h11112222, cyc);
        bus_wr(8'h0C, 32'h33334444, cyc);
        check("R7 held off", (cyc >= 10) ? 1 : 0, 1);
        bus_rd(8'h48, d); check("R7 second in flight", d, 32'h8);
        wait_clear();
        bus_rd(8'h0C, d); check("R7 later value lands", d, 32'h33334444);
        check("R7 f_regs", f_regs[3*DW +: DW], 32'h33334444);

        // R9 direct words
        bus_wr(8'h40, 32'hCAFE0001, cyc); check("R9 wake one cycle", cyc, 1);
        bus_wr(8'h44, 32'h0BAD0002, cyc); check("R9 capt one cycle", cyc, 1);
        bus_rd(8'h48, d); check("R9 no pending", d, '0);
        bus_rd(8'h40, d); check("R9 wake read", d, 32'hCAFE0001);
        bus_rd(8'h44, d); check("R9 capt read", d, 32'h0BAD0002);
        check("R9 wake port", wake_en, 32'hCAFE0001);
        check("R9 capt port", capt_val, 32'h0BAD0002);

        // R10 unmapped
        bus_rd(8'h3C, d); check("R10 read 0x3C", d, '0);
        bus_rd(8'h50, d); check("R10 read 0x50", d, '0);
        bus_rd(8'h01, d); check("R10 unaligned", d, '0);
        bus_wr(8'h30, 32'hDEADBEEF, cyc); check("R10 write ack", cyc, 1);
        bus_wr(8'h02, 32'hDEADBEEF, cyc); check("R10 unaligned write ack", cyc, 1);
        bus_rd(8'h30, d); check("R10 no store", d, '0);
        bus_rd(8'h48, d); check("R10 no pending", d, '0);
        bus_rd(8'h00, d); check("R10 reg0 untouched", d, last[0]);

        // back to non-posted, R6 again
        bus_wr(8'h54, 32'h0, cyc);
        bus_wr(8'h00, 32'h76543210, cyc);
        check("R6 stall again", (cyc >= 10) ? 1 : 0, 1);
        bus_rd(8'h48, d); check("R6 clean after ack", d, '0);

        // R5 one strobe per write
        repeat (6) @(posedge fclk);
        for (int i = 0; i < NC; i++) check("R5 strobe count", 32'(stb_cnt[i]), 32'(exp_cnt[i]));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule